// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits between a receive byte stream and system memory. It walks a ring of two-word descriptors, each pointing to a 128-byte buffer. It claims a free buffer, packs incoming bytes into 32-bit words and writes them into that buffer. A frame that does not fit in one buffer continues into the buffer of the next descriptor. When a buffer is finished, the block writes a status word and then hands the buffer over by setting its ownership flag.

Software sets the ring base address and the enable through a configuration input. It gives buffers back by clearing their ownership flags. When the next descriptor is still owned, the remainder of the frame is discarded and a one-cycle pulse reports the missing buffer. Memory is reached through one word-wide request port. A request is held until it is acknowledged, and a read returns its data in the acknowledge cycle.

Top module: `rx_ring_writer`

## Requirements
- R1: During reset and immediately after it, `mem_req`, `in_ready` and `nobuf_pulse` are 0.
- R2: A memory request holds `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`. Every request address has bits 1:0 equal to 0.
- R3: Descriptor word 0 (at descriptor address +0) holds the buffer address. Bit 0 is the ownership flag: 0 means free and 1 means filled. The buffer address used for writing is word 0 with bits 1:0 forced to 0.
- R4: Bytes are packed little-endian, so buffer byte n lands at buffer address + n. A partial final word is padded with zero bytes.
- R5: Each buffer takes at most 128 bytes. A longer frame continues into the buffer of the following descriptor.
- R6: Status word 1 (at descriptor address +4) has bit 14 set in the first buffer of a frame and bit 15 set in the last buffer. Bits 11:0 carry the total frame length in the last buffer and are 0 in the other buffers.
- R7: In the last buffer's status, bit 31 is `in_bcast`, bits 26, 25, 24 and 23 are `in_addr_hit[0]` to `in_addr_hit[3]`, and bit 22 is `in_type_hit`, all sampled with the last byte. These bits are 0 in the other buffers.
- R8: For each buffer, all data words are written first, then status word 1. Word 0 is written last, with its fetched value and bit 0 set.
- R9: After a buffer is completed, the next descriptor is the ring base if word 0 bit 1 (wrap) was set or if this was descriptor 31. Otherwise the next descriptor is at the current descriptor address + 8.
- R10: A frame that reaches a wrap continues its data in descriptor 0's buffer, at the start of the buffer area.
- R11: If a fetched descriptor is already owned, `nobuf_pulse` is high for one cycle. The rest of the frame is accepted and discarded with no memory write, and the same descriptor is fetched for the next frame.
- R12: While `cfg_enable` is 0 between frames, no descriptor is fetched, `in_ready` stays 0, and the descriptor pointer returns to `cfg_ring_base`.
- R13: `in_ready` is 0 whenever a memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Receive enable |
| cfg_ring_base | input | AW | Address of descriptor 0 |
| in_valid | input | 1 | Byte valid |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_bcast | input | 1 | Broadcast destination, valid with last byte |
| in_addr_hit | input | 4 | Specific-address match 1..4, valid with last byte |
| in_type_hit | input | 1 | Type-ID match, valid with last byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| nobuf_pulse | output | 1 | One-cycle pulse when an owned descriptor is met |

## Verification
The assertions take for granted that `mem_ack` comes only while `mem_req` is high and that read data is valid in that same acknowledge cycle. The bench memory model meets this by acknowledging one cycle after it sees a new request. The assertions also assume that software changes descriptors only while the block is idle. The stimulus therefore recycles ownership flags, sets wrap flags and toggles `cfg_enable` only after every expected descriptor hand-over has been seen and the stream is quiet. Flag inputs are held for the whole frame, so they are stable when the last byte is sampled.

// File: rtl/rxr_pkg.sv
// Package for the receive descriptor ring writer.
// It holds the controller states, the descriptor bit positions and the
// function that assembles a status word. It assumes 32-bit descriptor words.
package rxr_pkg;

    localparam int OWN_BIT   = 0;
    localparam int WRAP_BIT  = 1;
    localparam int LEN_W     = 12;
    localparam int FIRST_BIT = 14;
    localparam int LAST_BIT  = 15;
    localparam int TYPE_BIT  = 22;
    localparam int BCAST_BIT = 31;
    localparam int HIT1_BIT  = 26;  // address match 1; match k sits at 27-k

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FILL,
        ST_WDATA,
        ST_WSTAT,
        ST_WOWN,
        ST_DROP
    } rxr_state_t;

    // Build the status word for one buffer; length and match flags only in the last one
    function automatic logic [31:0] rxr_status(
        input logic             first,
        input logic             last,
        input logic [LEN_W-1:0] len,
        input logic             bcast,
        input logic [3:0]       hit,
        input logic             type_hit
    );
        logic [31:0] s;
        s = '0;
        s[FIRST_BIT] = first;
        if (last) begin
            s[LAST_BIT]      = 1'b1;
            s[LEN_W-1:0]     = len;
            s[BCAST_BIT]     = bcast;
            s[TYPE_BIT]      = type_hit;
            for (int k = 0; k < 4; k++) begin
                s[HIT1_BIT-k] = hit[k];
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/rxr_desc_ptr.sv
// Descriptor pointer for the receive ring.
// It holds the address and index of the current descriptor. On advance it
// steps by one descriptor (8 bytes), or returns to the base when the wrap
// flag was set or the last ring slot was used. Load returns it to the base.
// It assumes that load and advance are never raised together.
module rxr_desc_ptr #(
    parameter int AW         = 32,
    parameter int RING_DESCS = 32,
    localparam int IDX_W     = $clog2(RING_DESCS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base,
    input  logic          load,
    input  logic          advance,
    input  logic          wrap_flag,
    output logic [AW-1:0] ptr,
    output logic [IDX_W-1:0] idx
);

    logic at_end;
    assign at_end = (idx == IDX_W'(RING_DESCS - 1));

    // Pointer register: reset/load to base, wrap or step on advance
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            ptr <= base;
            idx <= '0;
        end else if (advance) begin
            if (wrap_flag || at_end) begin
                ptr <= base;
                idx <= '0;
            end else begin
                ptr <= ptr + AW'(8);
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxr_word_pack.sv
// Little-endian byte-to-word packer.
// Each pushed byte goes into the next lane of a 32-bit word. Clear empties
// the word to zero, so lanes that are not filled read as zero padding.
// It assumes that clear and push are never raised together.
module rxr_word_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        push,
    input  logic [7:0]  din,
    output logic [31:0] word,
    output logic [1:0]  lane
);

    // Word assembly: place the byte in its lane, or clear the word
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word <= '0;
            lane <= '0;
        end else if (push) begin
            word[lane*8 +: 8] <= din;
            lane              <= lane + 2'd1;
        end
    end

endmodule

// File: rtl/rx_ring_writer.sv
// Receive descriptor ring writer (top).
// It fetches a descriptor, fills its buffer with packed stream bytes, then
// writes the status word and sets ownership. It spreads long frames over
// consecutive buffers and drops the rest of a frame when it meets an owned
// descriptor. It assumes that mem_ack comes only while mem_req is high and
// that read data is valid with that mem_ack.
module rx_ring_writer #(
    parameter int AW         = 32,
    parameter int BUF_BYTES  = 128,
    parameter int RING_DESCS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic [AW-1:0] cfg_ring_base,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          in_bcast,
    input  logic [3:0]    in_addr_hit,
    input  logic          in_type_hit,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          nobuf_pulse
);
    import rxr_pkg::*;

    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int WOFF_W    = $clog2(BUF_WORDS);
    localparam int IDX_W     = $clog2(RING_DESCS);

    rxr_state_t        state;
    logic [AW-1:0]     ptr;
    logic [IDX_W-1:0]  idx;
    logic [AW-1:0]     buf_base;
    logic [31:0]       desc_w0;
    logic [WOFF_W-1:0] woff;
    logic [LEN_W-1:0]  frame_len;
    logic              first_buf;
    logic              last_seen;
    logic              fl_bcast;
    logic [3:0]        fl_hit;
    logic              fl_type;
    logic [31:0]       pack_word;
    logic [1:0]        pack_lane;
    logic              byte_take;
    logic              ptr_load;
    logic              ptr_adv;
    logic              pack_clear;
    logic              buf_full;
    logic [31:0]       status_word;

    assign byte_take  = in_valid && in_ready;
    assign ptr_load   = (state == ST_IDLE) && !cfg_enable;
    assign ptr_adv    = (state == ST_WOWN) && mem_ack;
    assign pack_clear = (state == ST_WDATA) && mem_ack;
    assign buf_full   = (woff == WOFF_W'(BUF_WORDS - 1));

    rxr_desc_ptr #(
        .AW         (AW),
        .RING_DESCS (RING_DESCS)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base      (cfg_ring_base),
        .load      (ptr_load),
        .advance   (ptr_adv),
        .wrap_flag (desc_w0[WRAP_BIT]),
        .ptr       (ptr),
        .idx       (idx)
    );

    rxr_word_pack u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pack_clear),
        .push  (byte_take && (state == ST_FILL)),
        .din   (in_data),
        .word  (pack_word),
        .lane  (pack_lane)
    );

    // Status for the buffer being closed
    assign status_word = rxr_status(first_buf, last_seen, frame_len,
                                    fl_bcast, fl_hit, fl_type);

    // Stream acceptance: only while filling or discarding, never during an access
    assign in_ready = (state == ST_FILL) || (state == ST_DROP);

    // Memory port: request, direction, address and data per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = '0;
        case (state)
            ST_FETCH: begin
                mem_req = 1'b1;
            end
            ST_WDATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_base + {{(AW-WOFF_W-2){1'b0}}, woff, 2'b00};
                mem_wdata = pack_word;
            end
            ST_WSTAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr + AW'(4);
                mem_wdata = status_word;
            end
            ST_WOWN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = desc_w0 | 32'h1;
            end
            default: ;
        endcase
    end

    // Controller: fetch, fill, write back, advance or drop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            buf_base    <= '0;
            desc_w0     <= '0;
            woff        <= '0;
            frame_len   <= '0;
            first_buf   <= 1'b1;
            last_seen   <= 1'b0;
            fl_bcast    <= 1'b0;
            fl_hit      <= '0;
            fl_type     <= 1'b0;
            nobuf_pulse <= 1'b0;
        end else begin
            nobuf_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    first_buf <= 1'b1;
                    last_seen <= 1'b0;
                    frame_len <= '0;
                    if (cfg_enable && in_valid) begin
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        if (mem_rdata[OWN_BIT]) begin
                            nobuf_pulse <= 1'b1;
                            state       <= ST_DROP;
                        end else begin
                            desc_w0  <= mem_rdata;
                            buf_base <= {mem_rdata[AW-1:2], 2'b00};
                            woff     <= '0;
                            state    <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (byte_take) begin
                        frame_len <= frame_len + 1'b1;
                        if (in_last) begin
                            last_seen <= 1'b1;
                            fl_bcast  <= in_bcast;
                            fl_hit    <= in_addr_hit;
                            fl_type   <= in_type_hit;
                        end
                        if (in_last || (pack_lane == 2'd3)) begin
                            state <= ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (mem_ack) begin
                        woff <= woff + 1'b1;
                        if (last_seen || buf_full) begin
                            state <= ST_WSTAT;
                        end else begin
                            state <= ST_FILL;
                        end
                    end
                end
                ST_WSTAT: begin
                    if (mem_ack) begin
                        state <= ST_WOWN;
                    end
                end
                ST_WOWN: begin
                    if (mem_ack) begin
                        first_buf <= 1'b0;
                        state     <= last_seen ? ST_IDLE : ST_FETCH;
                    end
                end
                ST_DROP: begin
                    if (byte_take && in_last) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxr_checker.sv
// Assertion checker for rx_ring_writer, bound to every instance.
// It assumes the memory acknowledges only requests that are pending.
module rxr_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic [31:0]   mem_rdata,
    input logic          nobuf_pulse
);

    // R2: a pending request keeps its address, direction and data
    p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R2: only word-aligned addresses are requested
    p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R11: the missing-buffer report lasts a single cycle
    p_nobuf_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        nobuf_pulse |=> !nobuf_pulse);

    // R11: a report follows an acknowledged read of an owned descriptor
    p_nobuf_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nobuf_pulse) |-> $past(mem_ack && !mem_we && mem_rdata[0]));

    // R13: no byte is accepted while a memory access is pending
    p_no_take_in_access_r13: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !mem_req);

endmodule

bind rx_ring_writer rxr_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .nobuf_pulse (nobuf_pulse)
);

// File: tb/sim_rx_ring_writer.sv
// Scoreboard bench for rx_ring_writer: the driver predicts every descriptor
// hand-over; the monitor checks each one as word 0 is written back.
module sim_rx_ring_writer;

    localparam int RING  = 32;
    localparam int BUFB  = 128;
    localparam logic [31:0] DBASE = 32'h1000;
    localparam logic [31:0] BBASE = 32'h2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [31:0] cfg_ring_base = DBASE;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_bcast = 1'b0;
    logic [3:0]  in_addr_hit = '0;
    logic        in_type_hit = 1'b0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        nobuf_pulse;

    always #4 clk = ~clk;  // 125 MHz

    rx_ring_writer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_ring_base(cfg_ring_base),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .in_bcast(in_bcast), .in_addr_hit(in_addr_hit), .in_type_hit(in_type_hit),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .nobuf_pulse(nobuf_pulse)
    );

    // Memory model: 16 KiB of words, acknowledge one cycle after a new request
    logic [31:0] mem [0:4095];
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[13:2]];
            end
        end
    end

    typedef struct {
        int          idx;
        logic [31:0] status;
        logic [31:0] w0;
        int          seed;
        int          off;
        int          nbytes;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    int exp_idx = 0;
    int exp_nobuf = 0;
    int seen_nobuf = 0;
    int bad_align = 0;
    int bad_ready = 0;
    int req_seen = 0;
    int frame_no = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int off);
        return 8'((seed * 37) + (off * 7) + 1);
    endfunction

    function automatic int dword0(input int i);
        return (int'(DBASE) >> 2) + 2 * i;
    endfunction

    // Monitor: descriptor hand-over checks, protocol counters
    always @(negedge clk) begin
        if (rst_n) begin
            if (nobuf_pulse) seen_nobuf++;
            if (mem_req) req_seen++;
            if (mem_req && mem_addr[1:0] != 2'b00) bad_align++;
            if (in_ready && mem_req) bad_ready++;
            if (mem_req && mem_we && mem_ack && mem_addr >= DBASE
                && mem_addr < DBASE + 32'(RING * 8) && mem_addr[2] == 1'b0) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected hand-over", mem_addr, 32'h0);
                end else begin
                    exp_t e;
                    int ba;
                    logic [7:0] got;
                    logic [7:0] want;
                    bit dok;
                    e = exp_q.pop_front();
                    chk(mem_addr == DBASE + 32'(e.idx * 8), "R9/R10 descriptor order",
                        mem_addr, DBASE + 32'(e.idx * 8));
                    chk(mem[mem_addr[13:2] + 1] == e.status, "R6/R7 status word",
                        mem[mem_addr[13:2] + 1], e.status);
                    chk(mem[mem_addr[13:2]] == (e.w0 | 32'h1), "R8/R3 ownership write",
                        mem[mem_addr[13:2]], e.w0 | 32'h1);
                    ba = int'(e.w0 & 32'hFFFF_FFFC);
                    dok = 1'b1;
                    got = '0;
                    want = '0;
                    for (int b = 0; b < ((e.nbytes + 3) / 4) * 4; b++) begin
                        logic [31:0] w;
                        logic [7:0] g;
                        logic [7:0] x;
                        w = mem[((ba + b) >> 2) & 4095];
                        g = w[((ba + b) % 4) * 8 +: 8];
                        x = (b < e.nbytes) ? pat(e.seed, e.off + b) : 8'h00;
                        if (g != x && dok) begin
                            dok = 1'b0;
                            got = g;
                            want = x;
                        end
                    end
                    chk(dok, "R4/R5 buffer data", {24'h0, got}, {24'h0, want});
                end
            end
        end
    end

    // Driver: predict hand-overs from the ring contents, then stream the frame
    task automatic send_frame(input int n, input logic bc, input logic [3:0] hit, input logic ty);
        int rem;
        int off;
        bit first;
        int seed;
        seed = frame_no;
        frame_no++;
        rem = n;
        off = 0;
        first = 1'b1;
        while (rem > 0) begin
            logic [31:0] w0;
            int chunk;
            exp_t e;
            w0 = mem[dword0(exp_idx)];
            if (w0[0]) begin
                exp_nobuf++;
                break;
            end
            chunk = (rem > BUFB) ? BUFB : rem;
            e.idx = exp_idx;
            e.w0 = w0;
            e.seed = seed;
            e.off = off;
            e.nbytes = chunk;
            e.status = '0;
            e.status[14] = first;
            if (chunk == rem) begin
                e.status[15] = 1'b1;
                e.status[11:0] = 12'(n);
                e.status[31] = bc;
                e.status[26] = hit[0];
                e.status[25] = hit[1];
                e.status[24] = hit[2];
                e.status[23] = hit[3];
                e.status[22] = ty;
            end
            exp_q.push_back(e);
            off += chunk;
            rem -= chunk;
            first = 1'b0;
            exp_idx = (w0[1] || exp_idx == RING - 1) ? 0 : exp_idx + 1;
        end
        for (int b = 0; b < n; b++) begin
            bit r;
            @(negedge clk);
            in_valid = 1'b1;
            in_data = pat(seed, b);
            in_last = (b == n - 1);
            in_bcast = bc;
            in_addr_hit = hit;
            in_type_hit = ty;
            forever begin
                r = in_ready;
                @(posedge clk);
                if (r) break;
                @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic recycle();
        for (int i = 0; i < RING; i++) mem[dword0(i)][0] = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        int nb0;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        for (int i = 0; i < RING; i++) begin
            mem[dword0(i)] = BBASE + 32'(i * BUFB);
            mem[dword0(i) + 1] = '0;
        end
        repeat (3) @(negedge clk);
        chk(mem_req == 1'b0 && in_ready == 1'b0 && nobuf_pulse == 1'b0, "R1 reset outputs",
            {29'h0, mem_req, in_ready, nobuf_pulse}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b0 && in_ready == 1'b0 && nobuf_pulse == 1'b0, "R1 after reset",
            {29'h0, mem_req, in_ready, nobuf_pulse}, 32'h0);
        cfg_enable = 1'b1;

        send_frame(60, 1'b1, 4'b0000, 1'b0);   wait_done();   // R6 R7 broadcast
        send_frame(300, 1'b0, 4'b0001, 1'b0);  wait_done();   // R5 three buffers, match 1
        send_frame(128, 1'b0, 4'b1000, 1'b0);  wait_done();   // R5 exact fill, match 4
        send_frame(129, 1'b0, 4'b0110, 1'b1);  wait_done();   // R5 one byte over, type
        send_frame(1, 1'b0, 4'b0000, 1'b0);    wait_done();   // R4 padding

        // R10 R3: wrap flag on descriptor 9, frame crosses to descriptor 0
        recycle();
        mem[dword0(9)][1] = 1'b1;
        send_frame(300, 1'b1, 4'b0100, 1'b0);  wait_done();

        // R12: disabled with bytes offered; no fetch, pointer back to base
        @(negedge clk);
        cfg_enable = 1'b0;
        nb0 = req_seen;
        in_valid = 1'b1;
        in_data = 8'hA5;
        repeat (20) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R12 not ready while disabled", {31'h0, in_ready}, 32'h0);
        end
        chk(req_seen == nb0, "R12 no fetch while disabled", 32'(req_seen - nb0), 32'h0);
        in_valid = 1'b0;
        cfg_enable = 1'b1;
        exp_idx = 0;
        recycle();
        send_frame(40, 1'b0, 4'b0010, 1'b0);   wait_done();   // R12 lands on descriptor 0

        // R11: owned descriptor at frame start
        mem[dword0(1)][0] = 1'b1;
        nb0 = req_seen;
        send_frame(50, 1'b0, 4'b0000, 1'b0);   wait_done();
        chk(seen_nobuf == exp_nobuf, "R11 pulse at frame start", 32'(seen_nobuf), 32'(exp_nobuf));
        chk(req_seen - nb0 == 2, "R11 only the fetch request", 32'(req_seen - nb0), 32'h2);
        mem[dword0(1)][0] = 1'b0;
        send_frame(70, 1'b0, 4'b0000, 1'b1);   wait_done();   // R11 same descriptor reused

        // R11: owned descriptor in the middle of a frame
        mem[dword0(3)][0] = 1'b1;
        send_frame(200, 1'b1, 4'b1111, 1'b1);  wait_done();
        chk(seen_nobuf == exp_nobuf, "R11 pulse mid-frame", 32'(seen_nobuf), 32'(exp_nobuf));
        mem[dword0(3)][0] = 1'b0;
        send_frame(20, 1'b0, 4'b0000, 1'b0);   wait_done();

        // R9: ring end without wrap flag returns to descriptor 0
        mem[dword0(9)][1] = 1'b0;
        @(negedge clk);
        cfg_enable = 1'b0;
        repeat (3) @(negedge clk);
        cfg_enable = 1'b1;
        exp_idx = 0;
        recycle();
        for (int f = 0; f < RING; f++) begin
            send_frame(10, 1'b0, 4'b0000, 1'b0);
            wait_done();
        end
        recycle();
        send_frame(10, 1'b0, 4'b0001, 1'b0);   wait_done();

        chk(bad_align == 0, "R2 aligned requests", 32'(bad_align), 32'h0);
        chk(bad_ready == 0, "R13 no byte taken during access", 32'(bad_ready), 32'h0);
        chk(exp_q.size() == 0, "R8 all hand-overs seen", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule